// File: doc/BRIEF.md
# Fiber Far-End Fault Signalling Unit

This block carries the in-band far-end fault protocol of one 100 Mb/s fiber port. On the receive side it watches the recovered serial bit stream, one bit per strobe of its bit-clock enable. It counts complete fault patterns, each of which is a run of exactly 84 one bits closed by a single zero bit. When three such patterns arrive back to back, it latches a remote-fault status bit. A set bit means that the far side is not receiving this port's transmit signal, so the local transmit path is faulty. The bit holds until management software reads the status register. In that register the bit sits at bit 4 of PHY status register 1.

On the transmit side the block sits between the normal coded bit stream and the line driver. While the local receiver cannot reach link-OK, it replaces the outgoing bits with the repeating fault pattern, which tells the far end about the failure. When link-OK returns, the block finishes the pattern it is sending and then hands the line back to the normal stream. In copper mode the whole mechanism is switched off.

Top module: `fefi_port`

## Requirements
- R1: On the receive side, a bit counts only on a cycle where `rx_bit_en` is high. A pattern occurrence is a zero bit that follows exactly 84 consecutive one bits.
- R2: `remote_fault` goes to 1 two clock cycles after the accepted zero bit that completes the third consecutive pattern occurrence. It stays 0 after one or two occurrences.
- R3: A zero bit that closes a run of any length other than 84 restarts the occurrence count at zero. Runs of 85 or more ones count as such a run, as do shorter runs.
- R4: `remote_fault` is sticky. A one-cycle `stat_rd` pulse clears it, with the result visible in the following cycle. If a new set arrives in the same cycle as the read, the set wins.
- R5: With `fiber_en` low, no pattern is detected and `remote_fault` is 0. `tx_bit_out` then takes the value of `tx_bit_in` on every `tx_bit_en` strobe.
- R6: With `fiber_en` high and `link_ok` low, each `tx_bit_en` strobe emits the next bit of a repeating pattern of 84 ones followed by one zero. The pattern starts with a one.
- R7: After `link_ok` returns, transmission continues up to and including the next zero of the pattern. The strobe after that zero carries `tx_bit_in` again. While `link_ok` is high and no pattern is in progress, `tx_bit_out` follows `tx_bit_in`.
- R8: `tx_bit_out` is registered. It changes only on a clock edge where `tx_bit_en` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| fiber_en | input | 1 | Port runs in fiber mode; enables detection and generation |
| rx_bit_en | input | 1 | Strobe marking a valid recovered receive bit |
| rx_bit | input | 1 | Recovered receive bit |
| link_ok | input | 1 | Local receiver has reached link-OK |
| stat_rd | input | 1 | Read strobe of the status register holding the fault bit |
| tx_bit_en | input | 1 | Transmit bit-rate strobe |
| tx_bit_in | input | 1 | Normal transmit code bit |
| tx_bit_out | output | 1 | Transmit bit toward the line coder |
| remote_fault | output | 1 | Latched far-end fault status |

## Verification
On the receive side, three exact patterns are sent back to back with zero bits placed between the strobes. This separates correct strobe qualification from a design that counts every clock. Runs of 85 and of 10 ones are then placed inside otherwise valid sequences, which separates an exact length match from a threshold compare and shows that the occurrence count really restarts. A read placed on the same cycle as a fresh set tests the priority between set and clear. On the transmit side, link loss produces several full patterns, and a link return in mid-pattern separates a stop at the pattern boundary from an immediate stop. Copper mode is run with the link down, so that a missing mode gate becomes visible as pattern bits.

// File: rtl/fefi_pkg.sv
package fefi_pkg;
  typedef enum logic {TX_PASS = 1'b0, TX_FAULT = 1'b1} tx_mode_t;
  localparam int unsigned DEF_RUN_LEN = 84;
  localparam int unsigned DEF_HITS    = 3;
endpackage

// File: rtl/fefi_rx_detect.sv
module fefi_rx_detect #(
  parameter int unsigned RUN_LEN = 84,
  parameter int unsigned HITS    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic bit_en,
  input  logic rx_bit,
  output logic hit
);
  localparam int unsigned RW = $clog2(RUN_LEN + 2);
  localparam int unsigned CW = $clog2(HITS + 1);
  localparam logic [RW-1:0] RUN_SAT = RW'(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_HIT = RW'(RUN_LEN);
  localparam logic [CW-1:0] LAST    = CW'(HITS - 1);

  logic [RW-1:0] run;
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || !fiber_en) begin
      run  <= '0;
      seen <= '0;
      hit  <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (bit_en) begin
        if (rx_bit) begin
          if (run != RUN_SAT) run <= run + 1'b1;
        end else begin
          run <= '0;
          if (run == RUN_HIT) begin
            if (seen == LAST) begin
              hit  <= 1'b1;
              seen <= '0;
            end else begin
              seen <= seen + 1'b1;
            end
          end else begin
            seen <= '0;
          end
        end
      end
    end
  end

  // a detection is always caused by an accepted zero bit
  p_hit_on_zero_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(bit_en && !rx_bit && fiber_en));
  // the occurrence counter never runs past its threshold
  p_seen_bound_r2: assert property (@(posedge clk) disable iff (rst)
    seen <= LAST);
endmodule

// File: rtl/fefi_status.sv
module fefi_status (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic hit,
  input  logic rd,
  output logic fault
);
  always_ff @(posedge clk) begin
    if (rst || !fiber_en) fault <= 1'b0;
    else if (hit)         fault <= 1'b1;
    else if (rd)          fault <= 1'b0;
  end

  p_set_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(hit));
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rd && !hit) |-> !fault);
  p_copper_off_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!fiber_en) |-> !fault);
endmodule

// File: rtl/fefi_tx_gen.sv
module fefi_tx_gen
  import fefi_pkg::*;
#(
  parameter int unsigned RUN_LEN = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic link_ok,
  input  logic bit_en,
  input  logic bit_in,
  output logic bit_out
);
  localparam int unsigned PW = $clog2(RUN_LEN + 1);
  localparam logic [PW-1:0] ZERO_POS = PW'(RUN_LEN);

  tx_mode_t      mode;
  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= TX_PASS;
      pos     <= '0;
      bit_out <= 1'b0;
    end else if (bit_en) begin
      if (!fiber_en) begin
        mode    <= TX_PASS;
        pos     <= '0;
        bit_out <= bit_in;
      end else if (mode == TX_PASS) begin
        if (!link_ok) begin
          mode    <= TX_FAULT;
          pos     <= PW'(1);
          bit_out <= 1'b1;
        end else begin
          bit_out <= bit_in;
        end
      end else if (pos == ZERO_POS) begin
        bit_out <= 1'b0;
        pos     <= '0;
        if (link_ok) mode <= TX_PASS;
      end else begin
        bit_out <= 1'b1;
        pos     <= pos + 1'b1;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!bit_en) |-> $stable(bit_out));
  p_copper_pass_r5: assert property (@(posedge clk) disable iff (rst)
    $past(bit_en && !fiber_en) |-> bit_out == $past(bit_in));
  p_zero_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    $past(bit_en && fiber_en && mode == TX_FAULT && pos != ZERO_POS) |-> bit_out);
endmodule

// File: rtl/fefi_port.sv
module fefi_port
  import fefi_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEF_RUN_LEN,
  parameter int unsigned HITS    = DEF_HITS
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic rx_bit_en,
  input  logic rx_bit,
  input  logic link_ok,
  input  logic stat_rd,
  input  logic tx_bit_en,
  input  logic tx_bit_in,
  output logic tx_bit_out,
  output logic remote_fault
);
  logic hit;

  fefi_rx_detect #(.RUN_LEN(RUN_LEN), .HITS(HITS)) u_rx (
    .clk(clk), .rst(rst), .fiber_en(fiber_en),
    .bit_en(rx_bit_en), .rx_bit(rx_bit), .hit(hit)
  );

  fefi_status u_stat (
    .clk(clk), .rst(rst), .fiber_en(fiber_en),
    .hit(hit), .rd(stat_rd), .fault(remote_fault)
  );

  fefi_tx_gen #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk(clk), .rst(rst), .fiber_en(fiber_en), .link_ok(link_ok),
    .bit_en(tx_bit_en), .bit_in(tx_bit_in), .bit_out(tx_bit_out)
  );
endmodule

// File: tb/tb_fefi_port.sv
`timescale 1ns/1ps
module tb_fefi_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fiber_en = 1'b0, rx_bit_en = 1'b0, rx_bit = 1'b0, link_ok = 1'b1;
  logic stat_rd = 1'b0, tx_bit_en = 1'b0, tx_bit_in = 1'b0;
  logic tx_bit_out, remote_fault;

  always #2.5 clk = ~clk;

  fefi_port dut (
    .clk(clk), .rst(rst), .fiber_en(fiber_en), .rx_bit_en(rx_bit_en),
    .rx_bit(rx_bit), .link_ok(link_ok), .stat_rd(stat_rd),
    .tx_bit_en(tx_bit_en), .tx_bit_in(tx_bit_in),
    .tx_bit_out(tx_bit_out), .remote_fault(remote_fault)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t q[$];
  logic mon_go = 1'b0;

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // transmit scoreboard: monitor compares after each strobe
  always @(posedge clk) mon_go <= tx_bit_en;
  always @(negedge clk) begin
    if (mon_go) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 actual=unexpected strobe expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(tx_bit_out, e.v, e.tag);
      end
    end
  end

  // bench model of the transmit requirements (R5..R7)
  bit m_send = 1'b0;
  int m_pos = 0;
  task automatic tx_step(input logic b, input string tag);
    exp_t e;
    e.tag = tag;
    if (!fiber_en) begin m_send = 0; e.v = b; end
    else if (!m_send) begin
      if (!link_ok) begin m_send = 1; m_pos = 1; e.v = 1'b1; end
      else e.v = b;
    end else if (m_pos == 84) begin
      e.v = 1'b0; m_pos = 0;
      if (link_ok) m_send = 0;
    end else begin
      e.v = 1'b1; m_pos++;
    end
    q.push_back(e);
    tx_bit_in = b; tx_bit_en = 1'b1;
    @(negedge clk);
    tx_bit_en = 1'b0;
  endtask

  task automatic rx_one(input logic b, input logic rd_after);
    rx_bit = b; rx_bit_en = 1'b1;
    @(negedge clk);
    rx_bit_en = 1'b0; rx_bit = 1'b0; stat_rd = rd_after;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic rx_pat(input int ones, input logic rd_on_set);
    for (int i = 0; i < ones; i++) rx_one(1'b1, 1'b0);
    rx_one(1'b0, rd_on_set);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check(tx_bit_out, 1'b0, "R8 reset tx");
    check(remote_fault, 1'b0, "R2 reset status");

    // R7 passthrough with link up
    fiber_en = 1'b1; link_ok = 1'b1;
    for (int i = 0; i < 6; i++) tx_step(logic'(i % 2), "R7 pass");
    // R8 hold without strobe
    tx_bit_in = ~tx_bit_out; idle(3);
    check(tx_bit_out, ~tx_bit_in, "R8 hold");

    // R6 pattern on link loss, R7 boundary stop
    link_ok = 1'b0;
    for (int i = 0; i < 85 * 2 + 30; i++) tx_step(1'b0, "R6 pattern");
    link_ok = 1'b1;
    for (int i = 0; i < 60; i++) tx_step(1'b0, "R7 boundary");
    // R5 copper mode with link down
    fiber_en = 1'b0; link_ok = 1'b0;
    for (int i = 0; i < 8; i++) tx_step(logic'(i % 3 == 0), "R5 copper tx");
    fiber_en = 1'b1; link_ok = 1'b1;
    for (int i = 0; i < 4; i++) tx_step(1'b1, "R7 pass again");
    idle(2);

    // R1/R2 three exact patterns
    rx_pat(84, 1'b0); rx_pat(84, 1'b0); idle(3);
    check(remote_fault, 1'b0, "R2 two patterns");
    rx_pat(84, 1'b0); idle(1);
    check(remote_fault, 1'b1, "R1 R2 third pattern");
    idle(5);
    check(remote_fault, 1'b1, "R4 sticky");
    rd_pulse();
    check(remote_fault, 1'b0, "R4 read clears");

    // R3 longer run restarts count
    rx_pat(84, 1'b0); rx_pat(85, 1'b0); rx_pat(84, 1'b0); rx_pat(84, 1'b0); idle(3);
    check(remote_fault, 1'b0, "R3 long run");
    rx_pat(84, 1'b0); idle(1);
    check(remote_fault, 1'b1, "R3 count after long run");
    rd_pulse();

    // R3 short run restarts count
    rx_pat(84, 1'b0); rx_pat(84, 1'b0); rx_pat(10, 1'b0); rx_pat(84, 1'b0); rx_pat(84, 1'b0); idle(3);
    check(remote_fault, 1'b0, "R3 short run");
    rx_pat(84, 1'b0); idle(1);
    check(remote_fault, 1'b1, "R3 count after short run");
    rd_pulse();
    check(remote_fault, 1'b0, "R4 clear again");

    // R4 set wins over simultaneous read
    rx_pat(84, 1'b0); rx_pat(84, 1'b0); rx_pat(84, 1'b1); idle(2);
    check(remote_fault, 1'b1, "R4 set beats read");
    rd_pulse();

    // R5 copper mode: no detection
    fiber_en = 1'b0;
    rx_pat(84, 1'b0); rx_pat(84, 1'b0); rx_pat(84, 1'b0); idle(3);
    check(remote_fault, 1'b0, "R5 copper rx");

    idle(2);
    check(q.size() == 0, 1'b1, "R8 all strobes seen");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule